// File: doc/BRIEF.md
# Command Completion Status Unit

This block follows a single disk command from start to end and produces the status word that is reported when the command completes. A command begins with a start strobe, which loads the running status word. While the command is active, per-field strobes record how far the transfer got. They do this through a two-bit progress code held in bits 13:12 of the status word. When the end strobe arrives, the unit does four things in the same cycle:

- it merges the raw controller status into the status word;
- it judges whether the command ended cleanly;
- it decides whether software should be notified;
- it decides whether the command chain stops or the next command is fetched.

The notify, halt, idle and fetch-next outputs are combinational and are valid only in the end-strobe cycle. After completion the stored status keeps only the low twelve bits it received from the controller, and the unit returns to idle. Writing the status to memory and delivering interrupts are handled elsewhere.

Top module: `cmd_status_unit`

## Requirements
- R1: After a synchronous active-low reset, `status_o` is 0 and `notify_o`, `halt_o`, `go_idle_o` and `fetch_next_o` are all 0.
- R2: A pulse on `start_i` loads `run_status_i` into `status_o` on the next clock and marks a command as active. A header strobe then sets bits 13:12 to 1.
- R3: While a command is active, the field strobes act on bits 13:12 as follows. A label strobe adds 1 modulo 4, so 3 wraps to 0. A data strobe forces the code to 3. A buffer-switch strobe clears it to 0. When several strobes arrive together, the priority is data, then buffer-switch, then label, then header.
- R4: Field strobes and end strobes that arrive while no command is active have no effect. `status_o` is unchanged and no completion output is raised.
- R5: In the end-strobe cycle of an active command, `final_status_o` bits 11:0 equal `ctrl_status_i` bits 11:0. Bits 14:12 equal the stored status bits 14:12.
- R6: The status is judged OK when `ctrl_status_i` equals exactly 0x0002 after its bits 15:12, bit 4 and bit 0 are cleared. Bit 1 means unit selected.
- R7: If the status is not OK, `final_status_o` bit 15 is set. Otherwise bit 15 keeps the stored value.
- R8: The notify policy comes from `cmd_i` bits 15:14. With 0, `notify_o` is never raised. With 1, `notify_o` equals final bit 15. With 2 or 3, `notify_o` is raised at every completion.
- R9: If the status is not OK and `cmd_i` bit 13 is set, `halt_o` pulses and the next pointer is treated as zero.
- R10: At completion, `go_idle_o` is raised when the effective next pointer is zero. Otherwise `fetch_next_o` is raised. These completion outputs pulse only in the end-strobe cycle of an active command.
- R11: On the clock after completion, `status_o` holds `ctrl_status_i[11:0]` with bits 15:12 cleared, and the command is no longer active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a command and load the running status |
| run_status_i | input | 16 | Running status word loaded at start |
| hdr_stb_i | input | 1 | Header field reached |
| lbl_stb_i | input | 1 | Label field reached |
| dat_stb_i | input | 1 | Data field reached |
| bsw_stb_i | input | 1 | Buffer-switch diagnostic clears the field code |
| end_stb_i | input | 1 | Command end |
| ctrl_status_i | input | 16 | Controller hardware status |
| cmd_i | input | 16 | Command word (notify policy, stop-on-error) |
| next_zero_i | input | 1 | Next command pointer is zero |
| status_o | output | 16 | Stored status word |
| final_status_o | output | 16 | Completion status word, valid with the end strobe |
| notify_o | output | 1 | Notify request pulse |
| halt_o | output | 1 | Chain halted on error |
| go_idle_o | output | 1 | Return to idle after completion |
| fetch_next_o | output | 1 | Fetch the next command after completion |

## Verification
The assertions take for granted that `start_i` and `end_stb_i` are never high in the same cycle. They also assume that `ctrl_status_i`, `cmd_i` and `next_zero_i` are stable and meaningful in the end-strobe cycle. The stimulus drives each strobe as a single-cycle pulse on the falling edge and never overlaps start with end. It holds the command and controller inputs constant across each end cycle, so the completion outputs are sampled while their inputs are settled.

// File: rtl/cmd_status_pkg.sv
// Package: shared widths, field positions and masks for the completion status unit.
// Assumes a 16-bit status word with the progress code just above the low controller bits.
package cmd_status_pkg;
    parameter int STAT_W   = 16;
    parameter int LOW_W    = 12;
    parameter int CODE_LSB = 12;
    parameter int CODE_W   = 2;
    parameter int FLAG_BIT = 15;

    localparam logic [STAT_W-1:0] OK_IGNORE = 16'hF011;
    localparam logic [STAT_W-1:0] OK_VALUE  = 16'h0002;

    localparam logic [CODE_W-1:0] CODE_NONE = 2'd0;
    localparam logic [CODE_W-1:0] CODE_HDR  = 2'd1;
    localparam logic [CODE_W-1:0] CODE_DATA = 2'd3;

    typedef enum logic [1:0] {
        POL_NONE    = 2'd0,
        POL_ON_ERR  = 2'd1,
        POL_ALWAYS  = 2'd2,
        POL_ALWAYS2 = 2'd3
    } notify_pol_e;
endpackage

// File: rtl/cst_field_tracker.sv
// Field tracker: holds the status word and the active flag, applies the field-progress
// strobes with a fixed priority and reloads the word at start and at completion.
// Assumes start and completion never occur in the same cycle; start wins if they do.
module cst_field_tracker
    import cmd_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STAT_W-1:0] run_status_i,
    input  logic              hdr_stb_i,
    input  logic              lbl_stb_i,
    input  logic              dat_stb_i,
    input  logic              bsw_stb_i,
    input  logic              done_i,
    input  logic [STAT_W-1:0] final_i,
    output logic [STAT_W-1:0] status_o,
    output logic              active_o
);
    logic [STAT_W-1:0] status_q;
    logic              active_q;
    logic [CODE_W-1:0] code_cur;
    logic [CODE_W-1:0] code_nxt;

    assign code_cur = status_q[CODE_LSB +: CODE_W];

    // Next progress code from the strobes: data, buffer-switch, label, header.
    always_comb begin
        code_nxt = code_cur;
        if (dat_stb_i)       code_nxt = CODE_DATA;
        else if (bsw_stb_i)  code_nxt = CODE_NONE;
        else if (lbl_stb_i)  code_nxt = code_cur + 1'b1;
        else if (hdr_stb_i)  code_nxt = CODE_HDR;
    end

    // Status register and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            active_q <= 1'b0;
        end else if (start_i) begin
            status_q <= run_status_i;
            active_q <= 1'b1;
        end else if (done_i) begin
            status_q <= {{(STAT_W-LOW_W){1'b0}}, final_i[LOW_W-1:0]};
            active_q <= 1'b0;
        end else if (active_q) begin
            status_q[CODE_LSB +: CODE_W] <= code_nxt;
        end
    end

    assign status_o = status_q;
    assign active_o = active_q;
endmodule

// File: rtl/cst_status_judge.sv
// Status judge: masks the controller status to decide success and merges it into
// the stored word to form the completion status. Purely combinational.
module cst_status_judge
    import cmd_status_pkg::*;
(
    input  logic [STAT_W-1:0] stored_i,
    input  logic [STAT_W-1:0] ctrl_i,
    output logic              ok_o,
    output logic [STAT_W-1:0] final_o
);
    logic [STAT_W-1:0] merged;

    // Success check and word merge.
    always_comb begin
        ok_o   = ((ctrl_i & ~OK_IGNORE) == OK_VALUE);
        merged = {stored_i[STAT_W-1:LOW_W], ctrl_i[LOW_W-1:0]};
        if (!ok_o) merged[FLAG_BIT] = 1'b1;
        final_o = merged;
    end
endmodule

// File: rtl/cst_chain_policy.sv
// Chain policy: from the completion event, the judged result and the command word,
// decides notify, halt and whether to idle or fetch the next command.
module cst_chain_policy
    import cmd_status_pkg::*;
#(
    parameter int POL_LSB  = 14,
    parameter int STOP_BIT = 13
) (
    input  logic              done_i,
    input  logic              ok_i,
    input  logic              flag_i,
    input  logic [STAT_W-1:0] cmd_i,
    input  logic              next_zero_i,
    output logic              notify_o,
    output logic              halt_o,
    output logic              go_idle_o,
    output logic              fetch_next_o
);
    notify_pol_e pol;
    logic        want_notify;
    logic        stop_now;

    assign pol = notify_pol_e'(cmd_i[POL_LSB +: 2]);

    // Notify decision from the two-bit policy.
    always_comb begin
        case (pol)
            POL_NONE:   want_notify = 1'b0;
            POL_ON_ERR: want_notify = flag_i;
            default:    want_notify = 1'b1;
        endcase
    end

    // Halt and chain continuation.
    always_comb begin
        stop_now     = !ok_i && cmd_i[STOP_BIT];
        notify_o     = done_i && want_notify;
        halt_o       = done_i && stop_now;
        go_idle_o    = done_i && (next_zero_i || stop_now);
        fetch_next_o = done_i && !(next_zero_i || stop_now);
    end
endmodule

// File: rtl/cmd_status_unit.sv
// Top: command completion status unit. Tracks field progress of the active command
// and, on the end strobe, emits the completion word and chain decisions.
// Assumes strobes are single-cycle and command inputs are valid with the end strobe.
module cmd_status_unit
    import cmd_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STAT_W-1:0] run_status_i,
    input  logic              hdr_stb_i,
    input  logic              lbl_stb_i,
    input  logic              dat_stb_i,
    input  logic              bsw_stb_i,
    input  logic              end_stb_i,
    input  logic [STAT_W-1:0] ctrl_status_i,
    input  logic [STAT_W-1:0] cmd_i,
    input  logic              next_zero_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] final_status_o,
    output logic              notify_o,
    output logic              halt_o,
    output logic              go_idle_o,
    output logic              fetch_next_o
);
    logic active;
    logic done;
    logic ok;

    assign done = end_stb_i && active && !start_i;

    cst_field_tracker u_track (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_status_i(run_status_i),
        .hdr_stb_i(hdr_stb_i), .lbl_stb_i(lbl_stb_i), .dat_stb_i(dat_stb_i),
        .bsw_stb_i(bsw_stb_i), .done_i(done), .final_i(final_status_o),
        .status_o(status_o), .active_o(active)
    );

    cst_status_judge u_judge (
        .stored_i(status_o), .ctrl_i(ctrl_status_i), .ok_o(ok), .final_o(final_status_o)
    );

    cst_chain_policy u_policy (
        .done_i(done), .ok_i(ok), .flag_i(final_status_o[FLAG_BIT]), .cmd_i(cmd_i),
        .next_zero_i(next_zero_i), .notify_o(notify_o), .halt_o(halt_o),
        .go_idle_o(go_idle_o), .fetch_next_o(fetch_next_o)
    );
endmodule

// File: rtl/cmd_status_unit_chk.sv
// Checker: temporal properties of the completion status unit, bound to the top.
module cmd_status_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        end_stb_i,
    input logic [15:0] ctrl_status_i,
    input logic [15:0] cmd_i,
    input logic [15:0] status_o,
    input logic [15:0] final_status_o,
    input logic        notify_o,
    input logic        halt_o,
    input logic        go_idle_o,
    input logic        fetch_next_o,
    input logic        active
);
    // R10
    excl_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_idle_o && fetch_next_o));

    // R9
    halt_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> go_idle_o);

    // R8
    quiet_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i[15:14] == 2'd0) |-> !notify_o);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start_i) |=> $stable(status_o));

    // R11
    clean_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_idle_o || fetch_next_o) |=> (status_o == {4'h0, $past(ctrl_status_i[11:0])} && !active));

    // R7
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((go_idle_o || fetch_next_o) && ((ctrl_status_i & 16'h0FEE) != 16'h0002)) |-> final_status_o[15]);

    // R10
    pulse_only_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_idle_o || fetch_next_o) |-> (end_stb_i && active));
endmodule

bind cmd_status_unit cmd_status_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_stb_i(end_stb_i),
    .ctrl_status_i(ctrl_status_i), .cmd_i(cmd_i), .status_o(status_o),
    .final_status_o(final_status_o), .notify_o(notify_o), .halt_o(halt_o),
    .go_idle_o(go_idle_o), .fetch_next_o(fetch_next_o), .active(active)
);

// File: tb/cmd_status_unit_tb_top.sv
// Directed bench for the completion status unit.
module cmd_status_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, hdr_stb_i = 1'b0, lbl_stb_i = 1'b0, dat_stb_i = 1'b0;
    logic        bsw_stb_i = 1'b0, end_stb_i = 1'b0, next_zero_i = 1'b0;
    logic [15:0] run_status_i = '0, ctrl_status_i = '0, cmd_i = '0;
    logic [15:0] status_o, final_status_o;
    logic        notify_o, halt_o, go_idle_o, fetch_next_o;
    int          checks = 0, failures = 0;

    always #2 clk = ~clk;

    cmd_status_unit dut_i (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [15:0] v);
        @(negedge clk); start_i = 1'b1; run_status_i = v;
        @(negedge clk); start_i = 1'b0;
    endtask

    // strobe vector order: data, bsw, label, header
    task automatic do_field(input logic [3:0] s);
        @(negedge clk); {dat_stb_i, bsw_stb_i, lbl_stb_i, hdr_stb_i} = s;
        @(negedge clk); {dat_stb_i, bsw_stb_i, lbl_stb_i, hdr_stb_i} = 4'b0;
    endtask

    // Drive an end strobe and check every completion output in that cycle.
    task automatic do_end(input string req, input logic [15:0] ctrl, input logic [15:0] cmd,
                          input logic nz, input logic [15:0] e_fin, input logic e_ntf,
                          input logic e_halt, input logic e_idle, input logic e_fetch);
        @(negedge clk); end_stb_i = 1'b1; ctrl_status_i = ctrl; cmd_i = cmd; next_zero_i = nz;
        #1;
        chk({req, " final"}, final_status_o, e_fin);
        chk({req, " notify"}, {15'b0, notify_o}, {15'b0, e_ntf});
        chk({req, " halt"}, {15'b0, halt_o}, {15'b0, e_halt});
        chk({req, " idle"}, {15'b0, go_idle_o}, {15'b0, e_idle});
        chk({req, " fetch"}, {15'b0, fetch_next_o}, {15'b0, e_fetch});
        @(negedge clk); end_stb_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_o, 16'h0);
        chk("R1 outs", {12'b0, notify_o, halt_o, go_idle_o, fetch_next_o}, 16'h0);
    endtask

    task automatic t_fields;
        do_start(16'h0ABC); chk("R2 load", status_o, 16'h0ABC);
        do_field(4'b0001); chk("R2 header", status_o, 16'h1ABC);
        do_field(4'b0010); chk("R3 label", status_o, 16'h2ABC);
        do_field(4'b1000); chk("R3 data", status_o, 16'h3ABC);
        do_field(4'b0010); chk("R3 wrap", status_o, 16'h0ABC);
        do_field(4'b1010); chk("R3 priority", status_o, 16'h3ABC);
        do_field(4'b0101); chk("R3 bufswitch", status_o, 16'h0ABC);
    endtask

    task automatic t_ok_end;
        do_start(16'h4000); do_field(4'b0001); do_field(4'b0010);
        chk("R3 code2", status_o, 16'h6000);
        do_end("R5 R6 ok", 16'hF013, 16'h0000, 1'b0, 16'h6013, 0, 0, 0, 1);
        chk("R11 cleared", status_o, 16'h0013);
    endtask

    task automatic t_idle_ignore;
        do_field(4'b0001); chk("R4 hdr idle", status_o, 16'h0013);
        do_field(4'b1000); chk("R4 data idle", status_o, 16'h0013);
        do_end("R4 end idle", 16'h0002, 16'hC000, 1'b1, 16'h0002, 0, 0, 0, 0);
        chk("R4 after", status_o, 16'h0013);
    endtask

    task automatic t_error_notify;
        do_start(16'h0000); do_field(4'b1000);
        do_end("R7 R8 err pol1", 16'h0402, 16'h4000, 1'b0, 16'hB402, 1, 0, 0, 1);
        do_start(16'h0000);
        do_end("R8 ok pol1", 16'h0002, 16'h4000, 1'b0, 16'h0002, 0, 0, 0, 1);
        do_start(16'h0000);
        do_end("R8 ok pol2", 16'h0002, 16'h8000, 1'b0, 16'h0002, 1, 0, 0, 1);
        do_start(16'h0000);
        do_end("R8 ok pol3", 16'h0002, 16'hC000, 1'b0, 16'h0002, 1, 0, 0, 1);
        do_start(16'h0000);
        do_end("R8 err pol0", 16'h0003 ^ 16'h0001 ^ 16'h0008, 16'h0000, 1'b0, 16'h800A, 0, 0, 0, 1);
    endtask

    task automatic t_halt;
        do_start(16'h1000);
        do_end("R9 halt", 16'h0000, 16'h2000, 1'b0, 16'h9000, 0, 1, 1, 0);
        do_start(16'h0000);
        do_end("R10 nz idle", 16'h0003, 16'h2000, 1'b1, 16'h0003, 0, 0, 1, 0);
        chk("R11 inactive", status_o, 16'h0003);
    endtask

    initial begin : watchdog
        #100000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_ok_end();
        t_idle_ignore();
        t_error_notify();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule